// File: doc/BRIEF.md
# Free-Running Timebase Counter with Clock Prescaler

This block is the 16-bit timebase that a capture/compare subsystem reads its time stamps from. The counter starts at zero when reset is released and advances by one each time the selected clock source produces an enable pulse. A built-in prescaler derives seven divided rates from the system clock. As an alternative source, the rising edges of an asynchronous external clock pin are synchronised into one-cycle enables. After reset the source is the system clock divided by four.

Software reaches the block through a small word-addressed register bus with byte enables. A word read returns the whole count as it stood in a single cycle. A byte read returns just the requested byte. No read ever changes the count. The count is read-only in normal operation. While the test mode or freeze mode input is high, software may load any value into it, and freeze mode also halts counting. When the count wraps from all ones to zero, an overflow flag is set. Software clears the flag by writing a one to it. An interrupt request is raised while both the flag and its enable are set.

Register map (bus_addr): 0 = count; 1 = control, with bits [2:0] the source code and bit 3 the overflow interrupt enable; 2 = status, with bit 0 the overflow flag; 3 = reads zero.

Top module: `tmr_timebase`

## Requirements
- R1: After a synchronous reset the count is 0x0000, the control register reads 0x0000 (source code 0, interrupt enable off), the status register reads 0x0000 and irq is low.
- R2: Source codes 0 to 6 in control bits [2:0] advance the count once every 4 << code system clock cycles, so any window of 512 cycles adds exactly 512 >> (code + 2). Counting continues in normal operation and cannot be halted by software.
- R3: Source code 7 selects the external clock. Each rising edge of ext_clk (each level held for at least two system clocks) adds exactly one to the count, and the count stays constant while ext_clk does not rise.
- R4: While freeze_mode is high the count does not advance, whatever the selected source does.
- R5: A write to address 0 is ignored unless test_mode or freeze_mode is high. When it is allowed, bus_be[0] loads bits [7:0] and bus_be[1] loads bits [15:8], and the written value takes precedence over an increment in the same cycle.
- R6: A read returns data on bus_rdata with bus_rvalid high one cycle after bus_rd. A word read (bus_be = 11) of address 0 returns all 16 bits of the count from a single cycle. Byte lanes whose enable is low read as zero, address 3 reads zero, and no read alters the count or the flag.
- R7: An increment from 0xFFFF gives 0x0000 and sets the overflow flag (status bit 0).
- R8: Writing status with bus_be[0] high and bus_wdata[0] = 1 clears the flag. Writing 0 leaves it unchanged. If a wrap occurs in the same cycle as a clear, the flag stays set.
- R9: irq is high exactly when the overflow flag and control bit 3 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | Asynchronous external count clock |
| test_mode | input | 1 | Test mode: permits count writes |
| freeze_mode | input | 1 | Freeze mode: halts counting and permits count writes |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register word address |
| bus_be | input | 2 | Byte enables (bit 0 = bits 7:0) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 1 | Overflow interrupt request |

## Verification
Assertions watch every cycle for several properties. An enabled tick advances the count by exactly one. The count is stable under freeze and under a refused write. A wrap lands on zero and sets the flag, and a clear that coincides with a wrap loses to it. A clear on its own drops the flag, a read leaves the flag alone, read data is valid the cycle after the strobe, and a synchronised external edge lasts a single cycle. Only the bench scenarios can show the division ratio of each tap and the one-for-one counting of external edges. The same holds for byte-lane merging of writes and reads, the reset contents, and the interrupt gating seen at the pin.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BUS_W      = 16;
  localparam int unsigned BE_W       = BUS_W / 8;
  localparam int unsigned CNT_W      = BUS_W;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned TAPS       = 7;
  localparam int unsigned FIRST_LOG2 = 2;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    A_COUNT = 2'd0,
    A_CTRL  = 2'd1,
    A_STAT  = 2'd2,
    A_NONE  = 2'd3
  } tmr_addr_e;
endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_tick
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[STAGES-1:0], async_in};
  end

  // previous synchronised level sits one stage further down the chain
  assign rise_tick = sync_q[STAGES-1] & ~sync_q[STAGES];

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise_tick |=> !rise_tick);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned NTAPS     = 7,
  parameter int unsigned LOW_LOG2  = 2,
  parameter int unsigned SELW      = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] sel,
  input  logic            ext_tick,
  output logic            tick
);
  localparam int unsigned DIV_W = LOW_LOG2 + NTAPS - 1;
  localparam int unsigned NSRC  = 2 ** SELW;

  logic [DIV_W-1:0] div_q;
  logic [NSRC-1:0]  src;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  // tap k fires when the low (LOW_LOG2 + k) divider bits are all ones
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    if (k < NTAPS) begin : g_tap
      assign src[k] = &div_q[LOW_LOG2+k-1:0];
    end else begin : g_ext
      assign src[k] = ext_tick;
    end
  end

  assign tick = src[sel];

  a_r2_fastest_tap_gap: assert property (@(posedge clk) disable iff (rst)
    src[0] |=> !src[0]);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned W   = 16,
  parameter int unsigned NBE = W / 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           freeze,
  input  logic           wr_allow,
  input  logic           wr_stb,
  input  logic [NBE-1:0] wr_be,
  input  logic [W-1:0]   wr_data,
  output logic [W-1:0]   count,
  output logic           wrap
);
  logic [W-1:0] count_q;
  logic         cnt_wr;
  logic         adv;

  assign cnt_wr = wr_stb & wr_allow & (|wr_be);
  assign adv    = tick & ~freeze & ~cnt_wr;
  assign wrap   = adv & (&count_q);
  assign count  = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (cnt_wr) begin
      for (int b = 0; b < NBE; b++) begin
        if (wr_be[b]) count_q[b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end else if (adv) begin
      count_q <= count_q + 1'b1;
    end
  end

  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    (tick && !freeze && !(wr_stb && wr_allow)) |=> count_q == W'($past(count_q) + 1'b1));
  a_r4_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    (freeze && !wr_stb) |=> $stable(count_q));
  a_r5_refused_write: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !wr_allow && !tick) |=> $stable(count_q));
  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |=> count_q == '0);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [BE_W-1:0]  bus_be,
  input  logic [SEL_W:0]   ctl_wdata,
  input  logic             stat_wbit,
  input  logic [CNT_W-1:0] count,
  input  logic             wrap,
  output logic [SEL_W-1:0] src_sel,
  output logic             irq,
  output logic [BUS_W-1:0] rdata,
  output logic             rvalid
);
  logic [SEL_W-1:0] sel_q;
  logic             ie_q;
  logic             flag_q;
  logic             clr;
  logic [BUS_W-1:0] raw;
  logic [BUS_W-1:0] masked;
  logic [BUS_W-1:0] rdata_q;
  logic             rvalid_q;
  tmr_addr_e        addr;

  assign addr = tmr_addr_e'(bus_addr);
  assign clr  = bus_wr & (addr == A_STAT) & bus_be[0] & stat_wbit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      ie_q  <= 1'b0;
    end else if (bus_wr && addr == A_CTRL && bus_be[0]) begin
      {ie_q, sel_q} <= ctl_wdata;
    end
  end

  // a wrap in the clearing cycle keeps the flag set
  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= wrap | (flag_q & ~clr);
  end

  always_comb begin
    raw = '0;
    unique case (addr)
      A_COUNT: raw = count;
      A_CTRL:  raw[SEL_W:0] = {ie_q, sel_q};
      A_STAT:  raw[0] = flag_q;
      default: raw = '0;
    endcase
    for (int b = 0; b < BE_W; b++) begin
      masked[b*8 +: 8] = bus_be[b] ? raw[b*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= masked;
    end
  end

  assign src_sel = sel_q;
  assign irq     = flag_q & ie_q;
  assign rdata   = rdata_q;
  assign rvalid  = rvalid_q;

  a_r7_flag_on_wrap: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag_q);
  a_r8_clear_alone: assert property (@(posedge clk) disable iff (rst)
    (clr && !wrap) |=> !flag_q);
  a_r6_read_keeps_flag: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && !wrap) |=> $stable(flag_q));
  a_r6_rvalid_next: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> rvalid_q);
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_clk,
  input  logic             test_mode,
  input  logic             freeze_mode,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [BE_W-1:0]  bus_be,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             bus_rvalid,
  output logic             irq
);
  logic             ext_tick;
  logic             tick;
  logic [SEL_W-1:0] src_sel;
  logic [CNT_W-1:0] count;
  logic             wrap;
  logic             cnt_stb;

  assign cnt_stb = bus_wr & (tmr_addr_e'(bus_addr) == A_COUNT);

  tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .async_in  (ext_clk),
    .rise_tick (ext_tick)
  );

  tmr_prescale #(.NTAPS(TAPS), .LOW_LOG2(FIRST_LOG2), .SELW(SEL_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .sel      (src_sel),
    .ext_tick (ext_tick),
    .tick     (tick)
  );

  tmr_count_core #(.W(CNT_W), .NBE(BE_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .freeze   (freeze_mode),
    .wr_allow (test_mode | freeze_mode),
    .wr_stb   (cnt_stb),
    .wr_be    (bus_be),
    .wr_data  (bus_wdata),
    .count    (count),
    .wrap     (wrap)
  );

  tmr_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .ctl_wdata (bus_wdata[SEL_W:0]),
    .stat_wbit (bus_wdata[0]),
    .count     (count),
    .wrap      (wrap),
    .src_sel   (src_sel),
    .irq       (irq),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid)
  );
endmodule

// File: tb/tb_tmr_timebase.sv
module tb_tmr_timebase;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_clk = 1'b0;
  logic        test_mode = 1'b0;
  logic        freeze_mode = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp;
    bit          raw;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  tmr_timebase dut (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .test_mode(test_mode),
    .freeze_mode(freeze_mode), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as read data comes back
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R6 unexpected rvalid", bus_rdata, 16'h0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (!it.raw) check(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic do_write(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b00;
  endtask

  task automatic do_read(input logic [1:0] a, input logic [1:0] be, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_be = be;
    sb_q.push_back('{exp: exp, raw: 1'b0, tag: tag});
    @(negedge clk);
    bus_rd = 1'b0; bus_be = 2'b00;
  endtask

  task automatic do_read_raw(output logic [15:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 2'd0; bus_be = 2'b11;
    sb_q.push_back('{exp: 16'h0, raw: 1'b1, tag: "raw"});
    @(negedge clk);
    bus_rd = 1'b0; bus_be = 2'b00;
    v = bus_rdata;
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_clk = 1'b1;
    repeat (3) @(negedge clk);
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %h expected %h", 16'h0, 16'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v1, v2, cnt;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    do_read(2'd0, 2'b11, 16'h0000, "R1 count after reset");
    do_read(2'd1, 2'b11, 16'h0000, "R1 control after reset");
    do_read(2'd2, 2'b11, 16'h0000, "R1 status after reset");
    check(irq === 1'b0, "R1 irq after reset", {15'h0, irq}, 16'h0);

    // R2 every prescaler tap over a 512-cycle window
    for (int c = 0; c < 7; c++) begin
      do_write(2'd1, 2'b01, 16'(c));
      repeat (3) @(negedge clk);
      do_read_raw(v1);
      repeat (510) @(negedge clk);
      do_read_raw(v2);
      check((v2 - v1) == 16'(512 >> (c + 2)), "R2 tap rate", v2 - v1, 16'(512 >> (c + 2)));
    end

    // R3/R5 external source, preset in test mode
    do_write(2'd1, 2'b01, 16'h0007);
    repeat (4) @(negedge clk);
    test_mode = 1'b1;
    do_write(2'd0, 2'b11, 16'h0100);
    test_mode = 1'b0;
    cnt = 16'h0100;
    do_read(2'd0, 2'b11, cnt, "R5 test mode word write");
    for (int i = 0; i < 5; i++) ext_pulse();
    cnt = cnt + 16'd5;
    do_read(2'd0, 2'b11, cnt, "R3 five external edges");
    do_read(2'd0, 2'b11, cnt, "R6 repeated read unchanged");
    do_read(2'd0, 2'b11, cnt, "R6 repeated read unchanged again");

    // R5 write refused in normal mode
    do_write(2'd0, 2'b11, 16'hABCD);
    do_read(2'd0, 2'b11, cnt, "R5 normal-mode write ignored");

    // R5 byte write, R6 byte reads
    test_mode = 1'b1;
    do_write(2'd0, 2'b10, 16'h7799);
    test_mode = 1'b0;
    cnt = {8'h77, cnt[7:0]};
    do_read(2'd0, 2'b01, {8'h00, cnt[7:0]}, "R6 low byte read");
    do_read(2'd0, 2'b10, {cnt[15:8], 8'h00}, "R6 high byte read");
    do_read(2'd3, 2'b11, 16'h0000, "R6 unused address");

    // R4 freeze halts, and permits a write
    freeze_mode = 1'b1;
    for (int i = 0; i < 3; i++) ext_pulse();
    do_read(2'd0, 2'b11, cnt, "R4 frozen count");
    do_write(2'd0, 2'b11, 16'h2222);
    cnt = 16'h2222;
    freeze_mode = 1'b0;
    do_read(2'd0, 2'b11, cnt, "R5 freeze-mode write");
    ext_pulse();
    cnt = cnt + 16'd1;
    do_read(2'd0, 2'b11, cnt, "R4 counting resumes");

    // R7 wrap sets flag; R9 gating; R8 clear
    test_mode = 1'b1;
    do_write(2'd0, 2'b11, 16'hFFFE);
    test_mode = 1'b0;
    ext_pulse(); ext_pulse();
    do_read(2'd0, 2'b11, 16'h0000, "R7 wrap to zero");
    do_read(2'd2, 2'b11, 16'h0001, "R7 overflow flag set");
    check(irq === 1'b0, "R9 irq masked", {15'h0, irq}, 16'h0);
    do_write(2'd1, 2'b01, 16'h000F);
    check(irq === 1'b1, "R9 irq enabled", {15'h0, irq}, 16'h1);
    do_write(2'd2, 2'b01, 16'h0000);
    do_read(2'd2, 2'b11, 16'h0001, "R8 write zero keeps flag");
    do_write(2'd2, 2'b01, 16'h0001);
    do_read(2'd2, 2'b11, 16'h0000, "R8 write one clears");
    check(irq === 1'b0, "R9 irq after clear", {15'h0, irq}, 16'h0);

    // R8 wrap coincides with clear
    test_mode = 1'b1;
    do_write(2'd0, 2'b11, 16'hFFFF);
    test_mode = 1'b0;
    @(negedge clk); ext_clk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd2; bus_be = 2'b01; bus_wdata = 16'h0001;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b00;
    repeat (2) @(negedge clk);
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);
    do_read(2'd2, 2'b11, 16'h0001, "R8 wrap beats clear");
    do_read(2'd0, 2'b11, 16'h0000, "R7 wrap during clear");
    do_write(2'd2, 2'b01, 16'h0001);

    // R2/R7/R9 wrap through the divide-by-four tap
    test_mode = 1'b1;
    do_write(2'd1, 2'b01, 16'h0008);
    do_write(2'd0, 2'b11, 16'hFFF0);
    test_mode = 1'b0;
    repeat (100) @(negedge clk);
    check(irq === 1'b1, "R9 irq after tap wrap", {15'h0, irq}, 16'h1);
    do_read(2'd2, 2'b11, 16'h0001, "R7 flag after tap wrap");

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R6 scoreboard drained", 16'(sb_q.size()), 16'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule